// File: doc/BRIEF.md
# Time-Division Slot-Table Circuit Router

This router carries guaranteed-throughput traffic between five input links and five output links without ever arbitrating. Time is cut into slots of one flit each (three 32-bit words on consecutive cycles). A free-running slot counter walks a 256-entry routing table. The entry for the current slot says, for every output, which input feeds it. Because every route is fixed ahead of time in the table, flits carry no header. A correct schedule never lets two flits compete for one link in the same slot.

Each input holds exactly one flit. A flit received during slot s is stored whole and sent out during slot s+1 (store-and-forward). Meanwhile the same input buffer takes in the next flit. The table is loaded through a simple write port. Loads go into a staging copy, which is made live only when the slot counter wraps. Entries therefore never change partway through a revolution. A flit that arrives on an input which no output selects is discarded and counted.

Top module: `tdmSlotRouter`

## Requirements
- R1: After reset, every outValid bit is 0, errCount is 0, slotNow is 0, and every live table entry routes nothing.
- R2: slotNow advances by one after every third clock edge following reset, and wraps from 255 to 0.
- R3: A table entry holds one 3-bit field per output, at bits [3o+2:3o] for output o. Code 0 means no input, and code i+1 means input i. A flit received in slot s leaves in slot s+1 on each output whose field in entry s selects its input. Word k of the flit is visible on outData in the cycle after edge k of slot s+1.
- R4: During a slot in which an output forwards no flit, that output keeps outValid low and its outData lane at zero for all three words.
- R5: An input's flit is present when inValid is high on the first word cycle of a slot. A new flit may arrive on the same input in every slot while the previous flit is being sent out.
- R6: A present flit whose input is selected by no output in the entry of its arrival slot is dropped. errCount then rises by the number of such flits in that slot, and it saturates at its maximum value (255).
- R7: Table writes take effect only at the next 255-to-0 wrap of the slot counter. A write made in the last cycle of slot 255 is already live in slot 0.
- R8: One input may be selected by several outputs in the same entry, and each of those outputs then carries a copy of the flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 160 | Input words, lane i at bits [32i+31:32i] |
| inValid | input | 5 | Per-input flit presence, sampled on the first word of a slot |
| cfgWrEn | input | 1 | Table write strobe |
| cfgAddr | input | 8 | Slot index being written |
| cfgEntry | input | 15 | Entry value, one 3-bit field per output |
| outData | output | 160 | Output words, lane o at bits [32o+31:32o] |
| outValid | output | 5 | Per-output word valid |
| slotNow | output | 8 | Current slot number of the shared time base |
| errCount | output | 8 | Saturating count of dropped flits |

## Verification
Two events can coincide at the wrap edge: a table write and the promotion of the staging copy to the live table. The bench issues a write in the final cycle of slot 255 and then sends a flit in the newly written slot during the next revolution. The write counts as merged only if that flit is forwarded. A second coincidence is a fresh flit entering an input buffer while the previous flit from the same input leaves it. Back-to-back slots on one input with distinct data patterns must each come out intact, one slot later.

// File: rtl/tdmRouterPkg.sv
package tdmRouterPkg;
  parameter int NUM_PORTS      = 5;
  parameter int WORDS_PER_FLIT = 3;
  parameter int PHASE_W        = $clog2(WORDS_PER_FLIT);
  parameter int SEL_W          = $clog2(NUM_PORTS + 1);
  parameter int ENTRY_W        = NUM_PORTS * SEL_W;

  typedef logic [SEL_W-1:0] portSel_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic               slotEnd;  // last word cycle of the slot
    logic [PHASE_W-1:0] phase;    // word index within the slot
    logic [ENTRY_W-1:0] entry;    // live table entry for this slot
  } ctlStrobe_t;
endpackage

// File: rtl/tdmSlotCtl.sv
module tdmSlotCtl
  import tdmRouterPkg::*;
#(
  parameter int NUM_SLOTS = 256,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [SLOT_W-1:0]  cfgAddr,
  input  logic [ENTRY_W-1:0] cfgEntry,
  output ctlStrobe_t         strobe,
  output logic [SLOT_W-1:0]  slotNow
);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(WORDS_PER_FLIT - 1);
  localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);

  logic [PHASE_W-1:0] phase;
  logic [SLOT_W-1:0]  slot;
  logic               lastWord, wrapNow;
  logic [ENTRY_W-1:0] stageTab [NUM_SLOTS];
  logic [ENTRY_W-1:0] liveTab  [NUM_SLOTS];

  assign lastWord = (phase == LAST_PHASE);
  assign wrapNow  = lastWord && (slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      slot  <= '0;
    end else begin
      phase <= lastWord ? '0 : phase + 1'b1;
      if (lastWord) slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end
  end

  // staging copy takes writes; live copy is refreshed only at the wrap
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gEntry
    logic hit;
    assign hit = cfgWrEn && (cfgAddr == SLOT_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageTab[k] <= '0;
        liveTab[k]  <= '0;
      end else begin
        if (hit)     stageTab[k] <= cfgEntry;
        if (wrapNow) liveTab[k]  <= hit ? cfgEntry : stageTab[k];
      end
    end
  end

  always_comb begin
    strobe.slotEnd = lastWord;
    strobe.phase   = phase;
    strobe.entry   = liveTab[slot];
  end

  assign slotNow = slot;
endmodule

// File: rtl/tdmFlitPath.sv
module tdmFlitPath
  import tdmRouterPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ERR_W  = 8,
  localparam int LANES_W = NUM_PORTS * WORD_W,
  localparam int CNT_W   = $clog2(NUM_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [LANES_W-1:0] inData,
  input  logic [NUM_PORTS-1:0] inValid,
  output logic [LANES_W-1:0] outData,
  output logic [NUM_PORTS-1:0] outValid,
  output logic [ERR_W-1:0]   errCount
);
  logic [WORD_W-1:0]    flitBuf [NUM_PORTS][WORDS_PER_FLIT];
  logic [NUM_PORTS-1:0] bufValid, mapped, fwdValid, slotValid;
  portSel_t             curSel  [NUM_PORTS];
  portSel_t             holdSel [NUM_PORTS];
  logic [WORD_W-1:0]    pickWord [NUM_PORTS];
  logic [CNT_W-1:0]     dropCnt;
  logic [ERR_W:0]       errSum;

  // one-flit input buffers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufValid <= '0;
    else if (strobe.phase == '0) bufValid <= inValid;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PORTS; i++)
      flitBuf[i][strobe.phase] <= inData[i*WORD_W +: WORD_W];
  end

  // decode the live entry for the arrival slot
  always_comb begin
    mapped   = '0;
    fwdValid = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      curSel[o] = strobe.entry[o*SEL_W +: SEL_W];
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (curSel[o] == portSel_t'(i + 1)) begin
          mapped[i]   = 1'b1;
          fwdValid[o] = bufValid[i];
        end
      end
    end
    dropCnt = CNT_W'($countones(bufValid & ~mapped));
    errSum  = {1'b0, errCount} + (ERR_W + 1)'(dropCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      errCount  <= '0;
      for (int o = 0; o < NUM_PORTS; o++) holdSel[o] <= '0;
    end else if (strobe.slotEnd) begin
      slotValid <= fwdValid;
      errCount  <= errSum[ERR_W] ? '1 : errSum[ERR_W-1:0];
      for (int o = 0; o < NUM_PORTS; o++) holdSel[o] <= curSel[o];
    end
  end

  // crossbar: each output reads its held input's current word
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      pickWord[o] = '0;
      for (int i = 0; i < NUM_PORTS; i++)
        if (holdSel[o] == portSel_t'(i + 1)) pickWord[o] = flitBuf[i][strobe.phase];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      outData  <= '0;
    end else begin
      for (int o = 0; o < NUM_PORTS; o++) begin
        outValid[o]                  <= slotValid[o];
        outData[o*WORD_W +: WORD_W]  <= slotValid[o] ? pickWord[o] : '0;
      end
    end
  end
endmodule

// File: rtl/tdmSlotRouter.sv
module tdmSlotRouter
  import tdmRouterPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_SLOTS = 256,
  parameter int ERR_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int LANES_W  = NUM_PORTS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANES_W-1:0]   inData,
  input  logic [NUM_PORTS-1:0] inValid,
  input  logic                 cfgWrEn,
  input  logic [SLOT_W-1:0]    cfgAddr,
  input  logic [ENTRY_W-1:0]   cfgEntry,
  output logic [LANES_W-1:0]   outData,
  output logic [NUM_PORTS-1:0] outValid,
  output logic [SLOT_W-1:0]    slotNow,
  output logic [ERR_W-1:0]     errCount
);
  ctlStrobe_t         strobe;
  logic [PHASE_W-1:0] phaseTap;

  assign phaseTap = strobe.phase;

  tdmSlotCtl #(.NUM_SLOTS(NUM_SLOTS)) ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgEntry(cfgEntry), .strobe(strobe), .slotNow(slotNow)
  );

  tdmFlitPath #(.WORD_W(WORD_W), .ERR_W(ERR_W)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .inValid(inValid), .outData(outData), .outValid(outValid),
    .errCount(errCount)
  );
endmodule

// File: rtl/tdmSlotRouterChk.sv
module tdmSlotRouterChk
  import tdmRouterPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_SLOTS = 256,
  parameter int ERR_W     = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [$clog2(NUM_SLOTS)-1:0]    slotNow,
  input logic [PHASE_W-1:0]              phase,
  input logic [NUM_PORTS-1:0]            outValid,
  input logic [NUM_PORTS*WORD_W-1:0]     outData,
  input logic [ERR_W-1:0]                errCount
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(WORDS_PER_FLIT - 1);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == LAST_PHASE) |->
      (slotNow == (($past(slotNow) == LAST_SLOT) ? '0 : $past(slotNow) + 1'b1)));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != '0) |-> $stable(slotNow));

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PHASE_W'(1)) |-> $stable(outValid));

  for (genvar o = 0; o < NUM_PORTS; o++) begin : gIdle
    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !outValid[o] |-> (outData[o*WORD_W +: WORD_W] == '0));
  end

  // R6
  err_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCount >= $past(errCount));

  // R6
  err_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCount) |-> (phase == '0));
endmodule

bind tdmSlotRouter tdmSlotRouterChk #(
  .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .ERR_W(ERR_W)
) routerChk (
  .clk(clk), .rstN(rstN), .slotNow(slotNow), .phase(phaseTap),
  .outValid(outValid), .outData(outData), .errCount(errCount)
);

// File: tb/tdmSlotRouter_test.sv
module tdmSlotRouter_test;
  import tdmRouterPkg::*;

  localparam int W    = 32;
  localparam int REV  = 256 * WORDS_PER_FLIT;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [NUM_PORTS*W-1:0] inData = '0;
  logic [NUM_PORTS-1:0]   inValid = '0;
  logic                   cfgWrEn = 1'b0;
  logic [7:0]             cfgAddr = '0;
  logic [ENTRY_W-1:0]     cfgEntry = '0;
  logic [NUM_PORTS*W-1:0] outData;
  logic [NUM_PORTS-1:0]   outValid;
  logic [7:0]             slotNow;
  logic [7:0]             errCount;

  int  vecs = 0;
  int  errs = 0;
  int  cyc  = 0;
  int  expErr = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  tdmSlotRouter uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgEntry(cfgEntry),
    .outData(outData), .outValid(outValid), .slotNow(slotNow),
    .errCount(errCount)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic gotoSlot(input int s);
    while ((cyc % REV) != s * WORDS_PER_FLIT) step();
  endtask

  function automatic logic [ENTRY_W-1:0] rt(input int o, input int i);
    rt = '0;
    rt[o*SEL_W +: SEL_W] = SEL_W'(i + 1);
  endfunction

  function automatic logic [W-1:0] pat(input int tag, input int i, input int k);
    pat = {16'(tag), 8'(i), 8'(k)};
  endfunction

  task automatic wrEntry(input int addr, input logic [ENTRY_W-1:0] ent);
    cfgWrEn = 1'b1; cfgAddr = 8'(addr); cfgEntry = ent;
    step();
    cfgWrEn = 1'b0; cfgAddr = '0; cfgEntry = '0;
  endtask

  // drive one slot of input words and check the output words of the same slot
  task automatic slotRun(input string req, input int sTag, input logic [NUM_PORTS-1:0] sMask,
                         input int eTag, input int eSrc [NUM_PORTS]);
    for (int k = 0; k < WORDS_PER_FLIT; k++) begin
      for (int i = 0; i < NUM_PORTS; i++) inData[i*W +: W] = pat(sTag, i, k);
      inValid = sMask;
      step();
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (eSrc[o] >= 0)
          chk(req, {31'd0, outValid[o], outData[o*W +: W]}, {31'd0, 1'b1, pat(eTag, eSrc[o], k)});
        else
          chk(req, {31'd0, outValid[o], outData[o*W +: W]}, 64'd0);
      end
    end
    inValid = '0;
    inData  = '0;
  endtask

  task automatic testReset();
    chk("R1 outValid", 64'(outValid), 64'd0);
    chk("R1 errCount", 64'(errCount), 64'd0);
    chk("R1 slotNow", 64'(slotNow), 64'd0);
  endtask

  task automatic testCounter();
    step(); step(); step();
    chk("R2 slot after 3 edges", 64'(slotNow), 64'd1);
  endtask

  task automatic testEmptyTable();
    gotoSlot(2);
    slotRun("R1 empty table", 1, 5'b00101, 0, '{-1, -1, -1, -1, -1});
    expErr += 2;
    slotRun("R4 idle outputs", 0, '0, 0, '{-1, -1, -1, -1, -1});
    chk("R6 drops counted", 64'(errCount), 64'(expErr));
  endtask

  task automatic testProgram();
    wrEntry(8, rt(2, 0) | rt(4, 3) | rt(0, 3));
    wrEntry(30, rt(1, 4));
    wrEntry(31, rt(1, 4));
    wrEntry(255, rt(0, 1));
    gotoSlot(8);
    slotRun("R7 not live before wrap", 2, 5'b01001, 0, '{-1, -1, -1, -1, -1});
    expErr += 2;
    slotRun("R7 not live before wrap", 0, '0, 0, '{-1, -1, -1, -1, -1});
    chk("R7 deferred write drops", 64'(errCount), 64'(expErr));
  endtask

  task automatic testWrapWrite();
    while ((cyc % REV) != REV - 1) step();
    chk("R2 last slot", 64'(slotNow), 64'd255);
    wrEntry(20, rt(3, 2));
    chk("R2 wrap to zero", 64'(slotNow), 64'd0);
  endtask

  task automatic testForward();
    gotoSlot(8);
    slotRun("R3 send", 5, 5'b01011, 0, '{-1, -1, -1, -1, -1});
    expErr += 1;
    slotRun("R8 multicast and R3 forward", 0, '0, 5, '{3, -1, 0, -1, 3});
    chk("R6 unmapped input dropped", 64'(errCount), 64'(expErr));
    gotoSlot(20);
    slotRun("R7 wrap write send", 6, 5'b00100, 0, '{-1, -1, -1, -1, -1});
    slotRun("R7 wrap-cycle write live", 0, '0, 6, '{-1, -1, -1, 2, -1});
  endtask

  task automatic testBackToBack();
    gotoSlot(30);
    slotRun("R5 first flit", 7, 5'b10000, 0, '{-1, -1, -1, -1, -1});
    slotRun("R5 overlap", 9, 5'b10000, 7, '{-1, 4, -1, -1, -1});
    slotRun("R5 second flit", 0, '0, 9, '{-1, 4, -1, -1, -1});
  endtask

  task automatic testLastSlot();
    gotoSlot(255);
    slotRun("R3 slot 255 send", 8, 5'b00010, 0, '{-1, -1, -1, -1, -1});
    slotRun("R3 forward across wrap", 0, '0, 8, '{1, -1, -1, -1, -1});
    chk("R2 second wrap", 64'(slotNow), 64'd1);
  endtask

  task automatic testSaturate();
    gotoSlot(40);
    for (int s = 0; s < 55; s++) begin
      slotRun("R6 flood", 10 + s, '1, 0, '{-1, -1, -1, -1, -1});
      expErr = (expErr + NUM_PORTS > 255) ? 255 : expErr + NUM_PORTS;
    end
    step();
    chk("R6 saturation", 64'(errCount), 64'(expErr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testCounter();
    testEmptyTable();
    testProgram();
    testWrapWrite();
    testForward();
    testBackToBack();
    testLastSlot();
    testSaturate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule